// File: doc/BRIEF.md
# DMA Channel Transfer Sequencing Counter

This block sequences one channel of a simple DMA engine. Software programs how many data units the channel must move, picks either a one-shot (normal) run or a wrapping (circular) run, and sets the enable bit. The datapath then reports each finished data unit with a one-cycle `xfer_done` strobe and any bus fault with a one-cycle `xfer_err` strobe. The block keeps a live remaining count, which software can read at any time. It also raises one-cycle pulses when the run reaches its midpoint, when the run finishes and when a fault stops it.

A private copy of the programmed count is taken whenever the count is written. A circular run refills the live count from that copy each time it reaches its end. The count port is locked while the channel is enabled, and so is the mode bit. In a normal run, the channel parks once the live count reaches zero. It stays enabled, but it accepts no more transfers until software clears the enable bit and writes a new count.

The controller has three states:
- OFF: the channel is disabled.
- RUN: the channel is enabled and has work left.
- SPENT: the channel is enabled but its count is zero.

The transitions are:
- OFF→RUN: enable is written with a non-zero count.
- OFF→SPENT: enable is written with a zero count.
- RUN→RUN: an ordinary step, or a circular reload.
- RUN→SPENT: the last transfer of a normal run.
- RUN→OFF: a software disable or a transfer error.
- SPENT→OFF: a software disable.

Top module: `xfer_seq_counter`

## Requirements
- R1: After reset, the block reports the following: `enabled`=0, `circular`=0, `remaining`=0, and `ev_half`, `ev_done` and `ev_err` all 0.
- R2: While the channel is disabled, `cnt_we` loads `cnt_wdata` into both the live count and the programmed copy. The new value is visible on `remaining` one cycle later. If `cnt_we` and an enable write arrive in the same cycle, the run starts from the newly written value.
- R3: A `cnt_we` while the channel is enabled has no effect on `remaining`.
- R4: While the channel is in RUN, each `xfer_done` lowers `remaining` by exactly one, visible in the next cycle.
- R5: In normal mode (`circular`=0), the transfer that takes `remaining` from 1 to 0 raises `ev_done` for one cycle. After that, `remaining` stays 0 and `enabled` stays 1. Further `xfer_done` strobes are ignored and raise no event.
- R6: In circular mode (`circular`=1), the final transfer raises `ev_done` and refills `remaining` with the programmed count. The channel keeps running, and later passes behave the same way.
- R7: `ev_half` pulses for one cycle in the cycle where `remaining` becomes floor(P/2), where P is the programmed count. It pulses once per pass and rearms on each circular reload. When P=1, it pulses together with `ev_done`.
- R8: In RUN, an `xfer_err` pulses `ev_err`, clears `enabled`, and leaves `remaining` at its current value.
- R9: `xfer_done` is ignored while the channel is disabled, and also when `remaining` is 0. In both cases `remaining` is unchanged and no event is raised.
- R10: Enabling with a count of 0 starts no run. No strobe then raises any event, and `remaining` stays 0.
- R11: A write with `ctl_we`=1 and `ctl_enable`=0 stops the channel. Re-enabling without a count write resumes from the remaining count that was left.
- R12: `ctl_circular` is taken only while the channel is disabled. A control write while the channel is enabled leaves `circular` unchanged.
- R13: The strobes are resolved in a fixed priority order:
  - When `xfer_err` and `xfer_done` arrive together, the error wins: there is no decrement and no `ev_done`.
  - When a disable write and `xfer_done` arrive together, the disable wins and the transfer is not counted.
- R14: Every event pulse appears in the cycle after its strobe, in the same cycle as the updated `remaining`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value for a control write |
| ctl_circular | input | 1 | Mode value for a control write (1 = circular) |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count value to program |
| xfer_done | input | 1 | One data unit moved (one-cycle strobe) |
| xfer_err | input | 1 | Transfer fault (one-cycle strobe) |
| remaining | output | 16 | Live remaining count |
| enabled | output | 1 | Channel enable bit |
| circular | output | 1 | Current mode bit |
| ev_half | output | 1 | Midpoint event pulse |
| ev_done | output | 1 | Run-complete event pulse |
| ev_err | output | 1 | Error event pulse |

## Verification
The counting path is driven with several stimulus patterns:
- An even count in normal mode, a short count and an odd count in circular mode, and a count of one. Together these separate the midpoint rounding, the park-at-zero behaviour and the reload behaviour, and show whether the midpoint rearms on each pass.
- Strobes while the channel is disabled, parked or unprogrammed, which show whether the gating is correct.
- Writes to the count and the mode while the channel is enabled, which show whether the write locks hold.
- Same-cycle collisions, which expose the priority order: error with done, disable with done, and count write with enable.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } xseq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2,
        OP_WRAP = 2'd3
    } cnt_op_e;

    localparam int EV_HALF = 0;
    localparam int EV_DONE = 1;
    localparam int EV_ERR  = 2;
    localparam int EV_N    = 3;

endpackage

// File: rtl/xseq_counter.sv
module xseq_counter
    import xseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] live,
    output logic             is_zero,
    output logic             is_last,
    output logic             half_cross
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] prog_q;
    logic [CNT_W-1:0] after_step;
    logic [CNT_W-1:0] half_mark;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            prog_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    live_q <= wdata;
                    prog_q <= wdata;
                end
                OP_STEP: live_q <= after_step;
                OP_WRAP: live_q <= prog_q;
                default: live_q <= live_q;
            endcase
        end
    end

    // Value the live count passes through on this transfer, and the midpoint
    always_comb begin
        after_step = live_q - ONE;
        half_mark  = prog_q >> 1;
        half_cross = (after_step == half_mark);
        is_zero    = (live_q == '0);
        is_last    = (live_q == ONE);
    end

    assign live = live_q;

endmodule

// File: rtl/xseq_fsm.sv
module xseq_fsm
    import xseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_enable,
    input  logic        ctl_circular,
    input  logic        cnt_we,
    input  logic        wdata_zero,
    input  logic        cnt_zero,
    input  logic        cnt_last,
    input  logic        xfer_done,
    input  logic        xfer_err,
    output xseq_state_e state,
    output logic        circ,
    output cnt_op_e     op,
    output logic        take_xfer,
    output logic        fire_done,
    output logic        fire_err
);
    xseq_state_e state_q, state_d;
    logic        circ_q;
    logic        start_zero;
    logic        sw_disable;
    logic        sw_enable;

    always_comb begin
        start_zero = cnt_we ? wdata_zero : cnt_zero;
        sw_disable = ctl_we && !ctl_enable;
        sw_enable  = ctl_we && ctl_enable;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Mode bit: only taken while the channel is off
    always_ff @(posedge clk) begin
        if (!rst_n)                          circ_q <= 1'b0;
        else if (state_q == ST_OFF && ctl_we) circ_q <= ctl_circular;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sw_enable) state_d = start_zero ? ST_SPENT : ST_RUN;
            end
            ST_RUN: begin
                if (xfer_err)                             state_d = ST_OFF;
                else if (sw_disable)                      state_d = ST_OFF;
                else if (xfer_done && cnt_last && !circ_q) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (sw_disable) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Output logic
    always_comb begin
        op        = OP_HOLD;
        take_xfer = 1'b0;
        fire_err  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cnt_we) op = OP_LOAD;
            end
            ST_RUN: begin
                if (xfer_err) begin
                    fire_err = 1'b1;
                end else if (!sw_disable && xfer_done) begin
                    take_xfer = 1'b1;
                    op        = (cnt_last && circ_q) ? OP_WRAP : OP_STEP;
                end
            end
            ST_SPENT: op = OP_HOLD;
            default:  op = OP_HOLD;
        endcase
        fire_done = take_xfer && cnt_last;
    end

    assign state = state_q;
    assign circ  = circ_q;

endmodule

// File: rtl/xseq_events.sv
module xseq_events
    import xseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] fire,
    output logic [EV_N-1:0] pulse
);
    for (genvar g = 0; g < EV_N; g++) begin : g_ev
        logic ev_q;
        always_ff @(posedge clk) begin
            if (!rst_n) ev_q <= 1'b0;
            else        ev_q <= fire[g];
        end
        assign pulse[g] = ev_q;
    end

endmodule

// File: rtl/xfer_seq_counter.sv
module xfer_seq_counter
    import xseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic             ctl_circular,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             xfer_done,
    input  logic             xfer_err,
    output logic [CNT_W-1:0] remaining,
    output logic             enabled,
    output logic             circular,
    output logic             ev_half,
    output logic             ev_done,
    output logic             ev_err
);
    xseq_state_e     state;
    cnt_op_e         op;
    logic            cnt_zero;
    logic            cnt_last;
    logic            half_cross;
    logic            take_xfer;
    logic            fire_done;
    logic            fire_err;
    logic [EV_N-1:0] fire;
    logic [EV_N-1:0] pulse;

    xseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_enable   (ctl_enable),
        .ctl_circular (ctl_circular),
        .cnt_we       (cnt_we),
        .wdata_zero   (cnt_wdata == '0),
        .cnt_zero     (cnt_zero),
        .cnt_last     (cnt_last),
        .xfer_done    (xfer_done),
        .xfer_err     (xfer_err),
        .state        (state),
        .circ         (circular),
        .op           (op),
        .take_xfer    (take_xfer),
        .fire_done    (fire_done),
        .fire_err     (fire_err)
    );

    xseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .wdata      (cnt_wdata),
        .live       (remaining),
        .is_zero    (cnt_zero),
        .is_last    (cnt_last),
        .half_cross (half_cross)
    );

    always_comb begin
        fire          = '0;
        fire[EV_HALF] = take_xfer && half_cross;
        fire[EV_DONE] = fire_done;
        fire[EV_ERR]  = fire_err;
    end

    xseq_events u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pulse (pulse)
    );

    assign enabled = (state != ST_OFF);
    assign ev_half = pulse[EV_HALF];
    assign ev_done = pulse[EV_DONE];
    assign ev_err  = pulse[EV_ERR];

endmodule

// File: rtl/xseq_checker.sv
module xseq_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             ctl_enable,
    input logic             cnt_we,
    input logic             xfer_done,
    input logic             xfer_err,
    input logic [CNT_W-1:0] remaining,
    input logic             enabled,
    input logic             circular,
    input logic             ev_half,
    input logic             ev_done,
    input logic             ev_err
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_locked_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && cnt_we && !xfer_done) |=> $stable(remaining));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && xfer_done && !xfer_err && !(ctl_we && !ctl_enable) && remaining > ONE)
        |=> (remaining == $past(remaining) - ONE));

    assert_normal_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !circular) |-> (remaining == '0 && enabled));

    assert_circular_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && circular) |-> (remaining != '0 && enabled));

    assert_error_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && remaining != '0 && xfer_err) |=> (!enabled && ev_err && $stable(remaining)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !cnt_we) |=> ($stable(remaining) && !ev_done && !ev_half));

    assert_err_over_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_err, ev_done}));

endmodule

bind xfer_seq_counter xseq_checker #(.CNT_W(CNT_W)) u_xseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_enable (ctl_enable),
    .cnt_we     (cnt_we),
    .xfer_done  (xfer_done),
    .xfer_err   (xfer_err),
    .remaining  (remaining),
    .enabled    (enabled),
    .circular   (circular),
    .ev_half    (ev_half),
    .ev_done    (ev_done),
    .ev_err     (ev_err)
);

// File: tb/xfer_seq_counter_bench.sv
module xfer_seq_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_enable = 1'b0, ctl_circular = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        xfer_done = 1'b0, xfer_err = 1'b0;
    logic [15:0] remaining;
    logic        enabled, circular, ev_half, ev_done, ev_err;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // Scoreboard queues
    logic [15:0] q_rem[$];
    logic [4:0]  q_flags[$];   // {enabled, circular, half, done, err}
    string       q_tag[$];

    // Bench model of the requirements
    logic        m_en = 1'b0, m_circ = 1'b0;
    logic [15:0] m_rem = '0, m_prog = '0;

    always #5 clk = ~clk;

    xfer_seq_counter u_xfer_seq_counter (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_circular(ctl_circular),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .xfer_done(xfer_done), .xfer_err(xfer_err),
        .remaining(remaining), .enabled(enabled), .circular(circular),
        .ev_half(ev_half), .ev_done(ev_done), .ev_err(ev_err)
    );

    task automatic step(input logic cw, input logic ce, input logic cc,
                        input logic nw, input logic [15:0] nd,
                        input logic dn, input logic er);
        logic h, d, e, running;
        logic [15:0] nxt;
        @(negedge clk);
        ctl_we = cw; ctl_enable = ce; ctl_circular = cc;
        cnt_we = nw; cnt_wdata = nd; xfer_done = dn; xfer_err = er;
        h = 1'b0; d = 1'b0; e = 1'b0;
        running = m_en && (m_rem != 16'd0);
        if (!m_en) begin
            if (nw) begin m_rem = nd; m_prog = nd; end
            if (cw) begin m_circ = cc; m_en = ce; end
        end else if (running && er) begin
            e = 1'b1; m_en = 1'b0;
        end else if (cw && !ce) begin
            m_en = 1'b0;
        end else if (running && dn) begin
            nxt = m_rem - 16'd1;
            if (nxt == (m_prog >> 1)) h = 1'b1;
            if (nxt == 16'd0) begin
                d = 1'b1;
                if (m_circ) nxt = m_prog;
            end
            m_rem = nxt;
        end
        q_rem.push_back(m_rem);
        q_flags.push_back({m_en, m_circ, h, d, e});
        q_tag.push_back(cur_tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 16'd0, 0, 0);
    endtask

    task automatic dones(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 16'd0, 1, 0);
    endtask

    // Monitor: compares each cycle's outputs after the edge
    always @(posedge clk) begin
        #2;
        if (q_rem.size() > 0) begin
            logic [15:0] er_;
            logic [4:0]  ef;
            string       tg;
            er_ = q_rem.pop_front();
            ef  = q_flags.pop_front();
            tg  = q_tag.pop_front();
            checks++;
            if (remaining !== er_ || {enabled, circular, ev_half, ev_done, ev_err} !== ef) begin
                errors++;
                $display("FAIL %s: remaining=%0d flags=%b expected remaining=%0d flags=%b",
                         tg, remaining, {enabled, circular, ev_half, ev_done, ev_err}, er_, ef);
            end
        end
    end

    initial begin
        #(10 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (remaining !== 16'd0 || {enabled, circular, ev_half, ev_done, ev_err} !== 5'b0) begin
            errors++;
            $display("FAIL R1: remaining=%0d flags=%b expected remaining=0 flags=00000",
                     remaining, {enabled, circular, ev_half, ev_done, ev_err});
        end

        cur_tag = "R9 strobe while disabled";  dones(2);
        cur_tag = "R10 zero count enable";     step(1, 1, 0, 0, 16'd0, 0, 0);
        cur_tag = "R10 strobes at zero";       dones(2);
        cur_tag = "R10 error at zero";         step(0, 0, 0, 0, 16'd0, 0, 1);
        cur_tag = "R11 disable";               step(1, 0, 0, 0, 16'd0, 0, 0);

        cur_tag = "R2 count write";            step(0, 0, 0, 1, 16'd8, 0, 0);
        cur_tag = "R2 enable normal";          step(1, 1, 0, 0, 16'd0, 0, 0);
        cur_tag = "R4 R7 R14 normal run of 8"; dones(8);
        cur_tag = "R5 strobe after park";      dones(2);
        cur_tag = "R3 write while parked";     step(0, 0, 0, 1, 16'd3, 0, 0);
        cur_tag = "R11 disable";               step(1, 0, 0, 0, 16'd0, 0, 0);

        cur_tag = "R2 write and enable circular same cycle"; step(1, 1, 1, 1, 16'd5, 0, 0);
        cur_tag = "R6 R7 circular odd pass";   dones(5);
        cur_tag = "R3 write while running";    step(0, 0, 0, 1, 16'd9, 1, 0);
        cur_tag = "R12 mode write while on";   step(1, 1, 0, 0, 16'd0, 0, 0);
        cur_tag = "R6 R7 second pass";         dones(6);
        cur_tag = "R13 disable with done";     step(1, 0, 1, 0, 16'd0, 1, 0);
        cur_tag = "R9 done while off";         dones(2);
        cur_tag = "R11 resume";                step(1, 1, 1, 0, 16'd0, 0, 0);
        cur_tag = "R11 R4 resumed steps";      dones(2);
        cur_tag = "R13 error with done";       step(0, 0, 0, 0, 16'd0, 1, 1);
        cur_tag = "R8 frozen after error";     dones(2);
        cur_tag = "R8 resume after error";     step(1, 1, 1, 0, 16'd0, 0, 0);
        cur_tag = "R8 error alone";            step(0, 0, 0, 0, 16'd0, 0, 1);
        idle(1);

        cur_tag = "R7 count of one";           step(0, 0, 0, 1, 16'd1, 0, 0);
        cur_tag = "R7 enable normal one";      step(1, 1, 0, 0, 16'd0, 0, 0);
        cur_tag = "R7 half with done";         dones(2);
        cur_tag = "R11 disable";               step(1, 0, 0, 0, 16'd0, 0, 0);

        cur_tag = "R2 count 2 circular";       step(1, 1, 1, 1, 16'd2, 0, 0);
        cur_tag = "R6 R7 short circular";      dones(5);
        idle(2);

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule